// File: doc/BRIEF.md
# STC Trust Checker

This block decides whether the running system time clock (STC) can be relied on at a given moment. It reads the upper 32-bit word of the STC twice through a simple register-read port. The first copy is the latched word, which the timing hardware captures each time a program clock reference (PCR) arrives. The second is the live word. It compares the two. If the live word has moved too far past the last latched copy, then no PCR has arrived within the expected interval and the time base is reported as untrusted.

A PCR can land in the middle of the read sequence and change the latched word. To catch this, the block reads the latched word, then the live word, then the latched word again. If the two latched copies differ, it runs the sequence once more. The caller raises a one-cycle request and, some cycles later, sees a one-cycle done pulse. At that pulse the live upper word and a trust flag are presented, and both are held until the next completion. The caller also supplies the number of PCRs received since the STC was last loaded. A count of zero always makes the result untrusted.

Top module: `stc_trust_check`

## Requirements
- R1: Each attempt issues exactly three reads on consecutive cycles: latched word (`regRdSel`=0), then live word (`regRdSel`=1), then latched word (`regRdSel`=0). The data for a read is taken from `regRdData` one cycle after `regRdEn`.
- R2: If the two latched copies of an attempt are equal, the sequence ends after that one attempt (two latched reads in total). `done` rises 6 clock edges after the edge that samples `startReq`.
- R3: If the two latched copies of the first attempt differ, exactly one more attempt runs (four latched reads in total). `done` then rises 11 edges after the edge that samples `startReq`.
- R4: If the two latched copies of the final attempt still differ, `stcValid` is 0.
- R5: The distance is the live word minus the first latched copy of the final attempt. `stcValid` is 0 when this distance exceeds `LIMIT` (default 4545). A distance of exactly `LIMIT` can still be valid.
- R6: The distance is an unsigned modulo-2^32 difference, so a live word that has wrapped past zero gives a small distance.
- R7: `stcValid` is 0 whenever `sampleCount` is zero at the decision.
- R8: At `done`, `stcWord` equals the live word read in the final attempt, whatever the value of `stcValid`.
- R9: After reset, `done`, `stcValid` and `stcWord` are 0. `done` is a one-cycle pulse. `stcValid` and `stcWord` do not change between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | One-cycle request to run a check; ignored while busy |
| sampleCount | input | CNT_W | PCRs received since the STC was loaded |
| regRdEn | output | 1 | Register read strobe |
| regRdSel | output | 1 | 0 = latched upper word, 1 = live upper word |
| regRdData | input | 32 | Read data, valid one cycle after `regRdEn` |
| done | output | 1 | One-cycle completion pulse |
| stcWord | output | 32 | Live upper STC word from the final attempt |
| stcValid | output | 1 | 1 when the time base is trusted |

## Verification
A wrong attempt counter or a wrong state step shows up on the read port within one attempt. It appears as a missing or extra read, a select out of order, or a `done` that arrives at the wrong edge (6 or 11). A capture register loaded in the wrong cycle mixes the live and latched words. That error shows at the next `done` as a wrong `stcWord`, or as a trust flag that flips for distances near `LIMIT` or across the wrap point. A decision that reads stale pair data flips `stcValid` only in runs where a mid-read PCR is injected, so those runs are mixed into the random stimulus.

// File: rtl/stc_trust_pkg.sv
package stc_trust_pkg;

  localparam logic SEL_LATCHED = 1'b0;
  localparam logic SEL_LIVE    = 1'b1;

  typedef struct packed {
    logic capLatchA;
    logic capLive;
    logic capLatchB;
    logic finish;
  } ctlStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_LA,
    ST_RD_LV,
    ST_RD_LB,
    ST_CAP_B,
    ST_DECIDE
  } ctlState_t;

endpackage

// File: rtl/stc_trust_ctl.sv
module stc_trust_ctl
  import stc_trust_pkg::*;
#(
  parameter int MAX_TRIES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        pairMatch,
  output logic        regRdEn,
  output logic        regRdSel,
  output logic        done,
  output ctlStrobes_t strobes
);

  localparam int TRY_W = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;

  ctlState_t        state, stateNext;
  logic [TRY_W-1:0] tryCnt;
  logic             clrTry, incTry, lastTry;

  assign lastTry = (tryCnt == TRY_W'(MAX_TRIES - 1));

  always_comb begin
    stateNext = state;
    strobes   = '0;
    regRdEn   = 1'b0;
    regRdSel  = SEL_LATCHED;
    clrTry    = 1'b0;
    incTry    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          clrTry    = 1'b1;
          stateNext = ST_RD_LA;
        end
      end
      ST_RD_LA: begin
        regRdEn   = 1'b1;
        regRdSel  = SEL_LATCHED;
        stateNext = ST_RD_LV;
      end
      ST_RD_LV: begin
        regRdEn           = 1'b1;
        regRdSel          = SEL_LIVE;
        strobes.capLatchA = 1'b1;
        stateNext         = ST_RD_LB;
      end
      ST_RD_LB: begin
        regRdEn         = 1'b1;
        regRdSel        = SEL_LATCHED;
        strobes.capLive = 1'b1;
        stateNext       = ST_CAP_B;
      end
      ST_CAP_B: begin
        strobes.capLatchB = 1'b1;
        stateNext         = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (pairMatch || lastTry) begin
          strobes.finish = 1'b1;
          stateNext      = ST_IDLE;
        end else begin
          incTry    = 1'b1;
          stateNext = ST_RD_LA;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      tryCnt <= '0;
      done   <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobes.finish;
      if (clrTry)      tryCnt <= '0;
      else if (incTry) tryCnt <= tryCnt + 1'b1;
    end
  end

endmodule

// File: rtl/stc_trust_dp.sv
module stc_trust_dp
  import stc_trust_pkg::*;
#(
  parameter int          WORD_W = 32,
  parameter int          CNT_W  = 8,
  parameter int unsigned LIMIT  = 4545
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [WORD_W-1:0] regRdData,
  input  logic [CNT_W-1:0]  sampleCount,
  output logic              pairMatch,
  output logic [WORD_W-1:0] stcWord,
  output logic              stcValid
);

  logic [WORD_W-1:0] latchA, latchB, liveW, distance;
  logic              inWindow, haveSamples;

  assign pairMatch   = (latchA == latchB);
  assign distance    = liveW - latchA;
  assign inWindow    = (distance <= WORD_W'(LIMIT));
  assign haveSamples = (sampleCount != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchA   <= '0;
      latchB   <= '0;
      liveW    <= '0;
      stcWord  <= '0;
      stcValid <= 1'b0;
    end else begin
      if (strobes.capLatchA) latchA <= regRdData;
      if (strobes.capLive)   liveW  <= regRdData;
      if (strobes.capLatchB) latchB <= regRdData;
      if (strobes.finish) begin
        stcWord  <= liveW;
        stcValid <= pairMatch && inWindow && haveSamples;
      end
    end
  end

endmodule

// File: rtl/stc_trust_check.sv
module stc_trust_check
  import stc_trust_pkg::*;
#(
  parameter int          CNT_W     = 8,
  parameter int unsigned LIMIT     = 4545,
  parameter int          MAX_TRIES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] sampleCount,
  output logic             regRdEn,
  output logic             regRdSel,
  input  logic [31:0]      regRdData,
  output logic             done,
  output logic [31:0]      stcWord,
  output logic             stcValid
);

  ctlStrobes_t strobes;
  logic        pairMatch;

  stc_trust_ctl #(.MAX_TRIES(MAX_TRIES)) u_ctl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .pairMatch(pairMatch),
    .regRdEn(regRdEn), .regRdSel(regRdSel), .done(done), .strobes(strobes)
  );

  stc_trust_dp #(.WORD_W(32), .CNT_W(CNT_W), .LIMIT(LIMIT)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regRdData(regRdData),
    .sampleCount(sampleCount), .pairMatch(pairMatch),
    .stcWord(stcWord), .stcValid(stcValid)
  );

endmodule

// File: rtl/stc_trust_chk.sv
module stc_trust_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             regRdEn,
  input logic             regRdSel,
  input logic             done,
  input logic [31:0]      stcWord,
  input logic             stcValid,
  input logic [CNT_W-1:0] sampleCount
);

  p_live_then_latched_r1: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regRdSel) |=> (regRdEn && !regRdSel));

  p_live_follows_latched_r1: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regRdSel) |-> $past(regRdEn && !regRdSel));

  p_no_read_at_done_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !regRdEn);

  p_zero_count_untrusted_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done && sampleCount == '0) |-> !stcValid);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_hold_status_r9: assert property (@(posedge clk) disable iff (!rstN)
    !done |=> ($stable(stcValid) || done));

  p_hold_word_r9: assert property (@(posedge clk) disable iff (!rstN)
    !done |=> ($stable(stcWord) || done));

endmodule

bind stc_trust_check stc_trust_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .regRdEn(regRdEn), .regRdSel(regRdSel),
  .done(done), .stcWord(stcWord), .stcValid(stcValid),
  .sampleCount(sampleCount)
);

// File: tb/tb_stc_trust_check.sv
module tb_stc_trust_check;

  localparam int          CLK_PERIOD = 10;
  localparam int          CNT_W      = 8;
  localparam int unsigned LIMIT      = 4545;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startReq = 1'b0;
  logic [CNT_W-1:0] sampleCount = '0;
  logic             regRdEn, regRdSel, done, stcValid;
  logic [31:0]      regRdData, stcWord;

  int total = 0;
  int bad   = 0;

  // bench-side register model
  logic [31:0] latchBase = '0, liveVal = '0, bumpAmt = '0;
  logic [3:0]  bumpMask = '0;
  int          latchIdx = 0;
  int          rdCount  = 0;
  logic [7:0]  selLog   = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] latchedAt(int n, logic [31:0] base, logic [3:0] m,
                                            logic [31:0] amt);
    logic [31:0] v = base;
    for (int k = 0; k < n && k < 4; k++) if (m[k]) v = v + amt;
    return v;
  endfunction

  always @(posedge clk) begin
    if (startReq) begin
      latchIdx <= 0;
      rdCount  <= 0;
      selLog   <= '0;
    end else if (regRdEn) begin
      if (rdCount < 8) selLog[rdCount] <= regRdSel;
      rdCount <= rdCount + 1;
      if (regRdSel) regRdData <= liveVal;
      else begin
        regRdData <= latchedAt(latchIdx, latchBase, bumpMask, bumpAmt);
        latchIdx  <= latchIdx + 1;
      end
    end
  end

  stc_trust_check #(.CNT_W(CNT_W), .LIMIT(LIMIT)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .sampleCount(sampleCount),
    .regRdEn(regRdEn), .regRdSel(regRdSel), .regRdData(regRdData),
    .done(done), .stcWord(stcWord), .stcValid(stcValid)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runCase(logic [31:0] base, logic [31:0] live, logic [3:0] m,
                         logic [31:0] amt, logic [CNT_W-1:0] cnt);
    logic [31:0] r0, r1, r2, r3, firstL;
    bit          retry, expValid;
    int          edges, expEdges, expReads;
    logic [31:0] holdWord;
    logic        holdValid;
    r0 = latchedAt(0, base, m, amt);
    r1 = latchedAt(1, base, m, amt);
    r2 = latchedAt(2, base, m, amt);
    r3 = latchedAt(3, base, m, amt);
    retry    = (r0 != r1);
    firstL   = retry ? r2 : r0;
    expValid = (retry ? (r2 == r3) : 1'b1) && ((live - firstL) <= LIMIT) && (cnt != 0);
    expEdges = retry ? 11 : 6;
    expReads = retry ? 6 : 3;

    @(negedge clk);
    latchBase = base; liveVal = live; bumpMask = m; bumpAmt = amt; sampleCount = cnt;
    startReq = 1'b1;
    edges = 0;
    @(posedge clk); edges++;
    @(negedge clk); startReq = 1'b0;
    while (!done && edges < 40) begin
      @(posedge clk); edges++;
      @(negedge clk);
    end
    check(edges == expEdges, retry ? "R3" : "R2", "done edge", edges, expEdges);
    check(rdCount == expReads, retry ? "R3" : "R2", "read count", rdCount, expReads);
    check(selLog[2:0] == 3'b010, "R1", "select order", selLog[2:0], 3'b010);
    if (retry) check(selLog[5:3] == 3'b010, "R1", "select order retry", selLog[5:3], 3'b010);
    check(stcValid == expValid, (cnt == 0) ? "R7" : (retry && r2 != r3) ? "R4" : "R5",
          "valid", stcValid, expValid);
    check(stcWord == live, "R8", "word", stcWord, live);
    holdWord = stcWord; holdValid = stcValid;
    @(negedge clk);
    check(done == 1'b0, "R9", "done pulse width", done, 0);
    latchBase = ~base; liveVal = ~live;
    repeat (3) @(negedge clk);
    check(stcWord == holdWord && stcValid == holdValid, "R9", "hold",
          {stcValid, stcWord}, {holdValid, holdWord});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5eed_1234));
    regRdData = '0;
    repeat (3) @(negedge clk);
    check(done == 0 && stcValid == 0 && stcWord == 0, "R9", "reset state",
          {done, stcValid, stcWord}, 0);
    rstN = 1'b1;
    @(negedge clk);

    runCase(32'h0000_1000, 32'h0000_1000 + LIMIT, 4'b0000, 0, 8'd3);      // R5 at limit
    runCase(32'h0000_1000, 32'h0000_1001 + LIMIT, 4'b0000, 0, 8'd3);      // R5 over limit
    runCase(32'hFFFF_FF00, 32'h0000_0050, 4'b0000, 0, 8'd1);              // R6 wrap, valid
    runCase(32'h0000_0050, 32'hFFFF_FF00, 4'b0000, 0, 8'd1);              // R6 reverse, invalid
    runCase(32'h0000_2000, 32'h0000_2010, 4'b0000, 0, 8'd0);              // R7
    runCase(32'h0000_2000, 32'h0000_2010, 4'b0001, 32'd5, 8'd4);          // R3 retry clean
    runCase(32'h0000_2000, 32'h0000_2010, 4'b0101, 32'd5, 8'd4);          // R4 still moving
    runCase(32'h0000_2000, 32'h0000_2000 + LIMIT + 3, 4'b0001, 32'd5, 8'd4); // R5 after retry
    runCase(32'h0000_3000, 32'h0000_3001, 4'b0010, 32'd9, 8'd2);          // R2 bump after pair

    for (int i = 0; i < 30; i++) begin
      logic [31:0] b, d;
      b = $urandom();
      d = LIMIT - 20 + ($urandom() % 41);
      if ($urandom() % 4 == 0) d = $urandom();
      runCase(b, b + d, 4'($urandom()), 32'($urandom() % 3 + 1), 8'($urandom() % 4));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule